// File: doc/BRIEF.md
# Parallel SAR Converter Host Sequencer

This block runs complete conversions on an external 14-bit successive-approximation converter that has a parallel data bus. It drives the converter's active-low chip select, the read/convert select line and its reset pin. It watches the active-low end-of-conversion flag and latches the data word. All timing is counted in system clock cycles. The timed values are the CS pulse widths, the acquisition time, the data-valid delay, the reference wake-up time, the conversion timeout and the reset pulse width.

A user asserts `start_valid` and chooses the power state the converter takes after the conversion with `start_standby`. The request is accepted when `start_ready` is high, and the request line is simply held while the block is busy.

Each conversion uses two chip-select falling edges. The first, taken with R/C low, wakes the converter and begins tracking. The second ends tracking and starts conversion, and the R/C level at that edge picks standby or shutdown. The block remembers whether the converter was left in shutdown. In that case it inserts the long reference wake-up wait before the second edge.

When the end-of-conversion flag falls, the word is read with a third chip-select low phase and returned with a one-cycle `sample_valid`. If that flag never falls in time, the block raises `timeout_err` and pulses the converter's reset pin with CS held high.

Top module: `sar_host_ctrl`

## Requirements
- R1: After synchronous reset, `adc_cs_n` is 1, `adc_reset` is 0, `sample_valid` is 0 and `start_ready` is 1.
- R2: At the first CS falling edge of every conversion, `adc_rc` is 0.
- R3: At the second CS falling edge, `adc_rc` equals the accepted `start_standby` value. A value of 1 selects standby and 0 selects shutdown.
- R4: Between the first and second CS falling edges, CS stays high for at least `T_ACQ` cycles.
- R5: If the converter was last left in shutdown, CS stays high between the first two edges for at least `T_WAKE + T_ACQ` cycles, and otherwise for fewer than `T_WAKE` cycles. The converter counts as left in shutdown after block reset, after a timeout, and after a conversion requested with `start_standby`=0.
- R6: After the end-of-conversion flag falls, CS goes low with `adc_rc`=1. The bus word is returned on `sample_data` with `sample_valid` high for exactly one cycle, and `sample_valid` is only raised right after a CS-low cycle.
- R7: `start_ready` is 0 from acceptance until the cycle has finished. A request held high during that time is accepted afterwards and served normally.
- R8: If the end-of-conversion flag has not fallen `T_EOC_TO` cycles after the second CS edge, `timeout_err` pulses and `adc_reset` is driven high with `adc_cs_n` high. No sample is returned for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Conversion request |
| start_standby | input | 1 | Power state after conversion: 1 standby, 0 shutdown |
| start_ready | output | 1 | Request accepted when high together with start_valid |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| sample_data | output | 14 | Captured converter word |
| timeout_err | output | 1 | One-cycle pulse when end of conversion timed out |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rc | output | 1 | Converter read/convert select |
| adc_reset | output | 1 | Converter reset pin, active high |
| adc_eoc_n | input | 1 | Converter end-of-conversion flag, active low, asynchronous |
| adc_data | input | 14 | Converter parallel data bus |

## Verification
The bench places a behavioural converter beside the block and runs a seeded random mix of standby and shutdown requests, varying the conversion delays and data words. This mix tells apart the wake-wait and no-wait paths, because each CS-high gap is checked against the power state the previous request left behind.

Directed cases cover several situations:
- the very first conversion after reset, which must wait;
- a converter that never signals completion, which must give the error and reset pulse and then force the next conversion to wait;
- requests held high during a busy cycle;
- the all-ones and all-zero data words.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EDGE1,
        ST_WAKE,
        ST_TRACK,
        ST_EDGE2,
        ST_CONV,
        ST_READ,
        ST_GAP,
        ST_RSTP
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic rc;
        logic rst;
    } adc_pins_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic adc_pins_t pins_for(input seq_state_t s, input logic standby);
        adc_pins_t p;
        p.cs_n = 1'b1;
        p.rc   = 1'b1;
        p.rst  = 1'b0;
        case (s)
            ST_EDGE1: begin p.cs_n = 1'b0; p.rc = 1'b0;    end
            ST_EDGE2: begin p.cs_n = 1'b0; p.rc = standby; end
            ST_READ:  begin p.cs_n = 1'b0; p.rc = 1'b1;    end
            ST_RSTP:  begin p.rst  = 1'b1;                 end
            default:  ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sar_eoc_sync.sv
module sar_eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], async_n};
    end

    assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/sar_cycle_timer.sv
module sar_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val - W'(1);
        else if (cnt != '0)   cnt <= cnt - W'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_host_pkg::*;
#(
    parameter int W        = 8,
    parameter int T_CSL    = 3,
    parameter int T_CSH    = 3,
    parameter int T_ACQ    = 8,
    parameter int T_DV     = 2,
    parameter int T_WAKE   = 100,
    parameter int T_EOC_TO = 100,
    parameter int T_RST    = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_valid,
    input  logic         start_standby,
    input  logic         timer_done,
    input  logic         eoc_n,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output logic         start_ready,
    output logic         capture_en,
    output logic         err_pulse,
    output adc_pins_t    pins
);
    seq_state_t state, state_nx;
    logic       standby_q;
    logic       shut_q;
    logic       err_nx;

    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = W'(1);
        capture_en = 1'b0;
        err_nx   = 1'b0;
        case (state)
            ST_IDLE: if (start_valid) begin
                state_nx = ST_EDGE1; tmr_load = 1'b1; tmr_val = W'(T_CSL);
            end
            ST_EDGE1: if (timer_done) begin
                tmr_load = 1'b1;
                if (shut_q) begin state_nx = ST_WAKE;  tmr_val = W'(T_WAKE); end
                else        begin state_nx = ST_TRACK; tmr_val = W'(T_ACQ);  end
            end
            ST_WAKE: if (timer_done) begin
                state_nx = ST_TRACK; tmr_load = 1'b1; tmr_val = W'(T_ACQ);
            end
            ST_TRACK: if (timer_done) begin
                state_nx = ST_EDGE2; tmr_load = 1'b1; tmr_val = W'(T_CSL);
            end
            ST_EDGE2: if (timer_done) begin
                state_nx = ST_CONV; tmr_load = 1'b1; tmr_val = W'(T_EOC_TO);
            end
            ST_CONV: begin
                if (!eoc_n) begin
                    state_nx = ST_READ; tmr_load = 1'b1; tmr_val = W'(T_DV);
                end else if (timer_done) begin
                    state_nx = ST_RSTP; tmr_load = 1'b1; tmr_val = W'(T_RST);
                    err_nx   = 1'b1;
                end
            end
            ST_READ: if (timer_done) begin
                state_nx = ST_GAP; tmr_load = 1'b1; tmr_val = W'(T_CSH);
                capture_en = 1'b1;
            end
            ST_GAP:  if (timer_done) state_nx = ST_IDLE;
            ST_RSTP: if (timer_done) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            standby_q <= 1'b0;
            shut_q    <= 1'b1;
            err_pulse <= 1'b0;
        end else begin
            state     <= state_nx;
            err_pulse <= err_nx;
            if (state == ST_IDLE && start_valid) standby_q <= start_standby;
            if (state == ST_CONV && !eoc_n)      shut_q    <= ~standby_q;
            else if (err_nx)                     shut_q    <= 1'b1;
        end
    end

    assign start_ready = (state == ST_IDLE);
    assign pins        = pins_for(state, standby_q);
endmodule

// File: rtl/sar_capture.sv
module sar_capture #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture_en,
    input  logic [DW-1:0] bus,
    output logic          valid,
    output logic [DW-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= capture_en;
            if (capture_en) data <= bus;
        end
    end
endmodule

// File: rtl/sar_host_ctrl.sv
module sar_host_ctrl
    import sar_host_pkg::*;
#(
    parameter int DW        = 14,
    parameter int SYNC_STG  = 2,
    parameter int T_CSL     = 4,
    parameter int T_CSH     = 4,
    parameter int T_ACQ     = 60,
    parameter int T_DV      = 4,
    parameter int T_WAKE    = 1200000,
    parameter int T_EOC_TO  = 1000,
    parameter int T_RST     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_valid,
    input  logic          start_standby,
    output logic          start_ready,
    output logic          sample_valid,
    output logic [DW-1:0] sample_data,
    output logic          timeout_err,
    output logic          adc_cs_n,
    output logic          adc_rc,
    output logic          adc_reset,
    input  logic          adc_eoc_n,
    input  logic [DW-1:0] adc_data
);
    localparam int unsigned MAXV = max_of(max_of(max_of(T_CSL, T_CSH), max_of(T_ACQ, T_DV)),
                                          max_of(max_of(T_WAKE, T_EOC_TO), T_RST));
    localparam int W = $clog2(MAXV + 1);

    logic         eoc_s_n;
    logic         tmr_load;
    logic [W-1:0] tmr_val;
    logic         tmr_done;
    logic         capture_en;
    adc_pins_t    pins;

    sar_eoc_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst(rst), .async_n(adc_eoc_n), .sync_n(eoc_s_n)
    );

    sar_cycle_timer #(.W(W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    sar_seq_fsm #(
        .W(W), .T_CSL(T_CSL), .T_CSH(T_CSH), .T_ACQ(T_ACQ), .T_DV(T_DV),
        .T_WAKE(T_WAKE), .T_EOC_TO(T_EOC_TO), .T_RST(T_RST)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_standby(start_standby),
        .timer_done(tmr_done), .eoc_n(eoc_s_n),
        .tmr_load(tmr_load), .tmr_val(tmr_val),
        .start_ready(start_ready), .capture_en(capture_en),
        .err_pulse(timeout_err), .pins(pins)
    );

    sar_capture #(.DW(DW)) u_cap (
        .clk(clk), .rst(rst), .capture_en(capture_en), .bus(adc_data),
        .valid(sample_valid), .data(sample_data)
    );

    assign adc_cs_n  = pins.cs_n;
    assign adc_rc    = pins.rc;
    assign adc_reset = pins.rst;
endmodule

// File: rtl/sar_host_chk.sv
module sar_host_chk (
    input logic clk,
    input logic rst,
    input logic start_ready,
    input logic sample_valid,
    input logic timeout_err,
    input logic adc_cs_n,
    input logic adc_reset
);
    // R8
    err_with_reset_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> adc_reset);

    // R8
    reset_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
        adc_reset |-> adc_cs_n);

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    // R6
    valid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> $past(!adc_cs_n));

    // R7
    ready_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start_ready |-> (adc_cs_n && !adc_reset));
endmodule

bind sar_host_ctrl sar_host_chk u_chk (
    .clk(clk), .rst(rst), .start_ready(start_ready), .sample_valid(sample_valid),
    .timeout_err(timeout_err), .adc_cs_n(adc_cs_n), .adc_reset(adc_reset)
);

// File: tb/test_sar_host_ctrl.sv
module test_sar_host_ctrl;
    localparam int DW = 14, T_CSL = 3, T_CSH = 3, T_ACQ = 8, T_DV = 2;
    localparam int T_WAKE = 300, T_EOC_TO = 120, T_RST = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic start_valid = 1'b0, start_standby = 1'b0;
    logic start_ready, sample_valid, timeout_err, adc_cs_n, adc_rc, adc_reset;
    logic [DW-1:0] sample_data, adc_data;
    logic adc_eoc_n = 1'b1;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    sar_host_ctrl #(.DW(DW), .T_CSL(T_CSL), .T_CSH(T_CSH), .T_ACQ(T_ACQ), .T_DV(T_DV),
                    .T_WAKE(T_WAKE), .T_EOC_TO(T_EOC_TO), .T_RST(T_RST)) i_sar_host_ctrl (
        .clk(clk), .rst(rst), .start_valid(start_valid), .start_standby(start_standby),
        .start_ready(start_ready), .sample_valid(sample_valid), .sample_data(sample_data),
        .timeout_err(timeout_err), .adc_cs_n(adc_cs_n), .adc_rc(adc_rc), .adc_reset(adc_reset),
        .adc_eoc_n(adc_eoc_n), .adc_data(adc_data)
    );

    // behavioural converter
    int unsigned   cyc = 0, rise_t = 0, gap = 0, cd = 0;
    int unsigned   plan_dly = 5;
    logic          plan_never = 1'b0;
    logic [DW-1:0] plan_data = '0;
    int            ph = 0;
    logic prev_cs = 1'b1, eoc_done = 1'b0, rc1 = 1'b1, rc2 = 1'b0, rc_rd = 1'b0;
    logic rst_seen = 1'b0, bad_rst = 1'b0;

    assign adc_data = (!adc_cs_n && eoc_done) ? plan_data : '0;

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        prev_cs <= adc_cs_n;
        if (adc_reset) begin
            ph <= 0; adc_eoc_n <= 1'b1; eoc_done <= 1'b0; rst_seen <= 1'b1;
            if (!adc_cs_n) bad_rst <= 1'b1;
        end else if (prev_cs && !adc_cs_n) begin
            if (ph == 0) begin
                rc1 <= adc_rc; ph <= 1; adc_eoc_n <= 1'b1; eoc_done <= 1'b0;
            end else if (ph == 1) begin
                rc2 <= adc_rc; gap <= cyc - rise_t; ph <= 2; cd <= plan_dly;
            end else if (eoc_done) begin
                rc_rd <= adc_rc; ph <= 0;
            end
        end else if (!prev_cs && adc_cs_n && ph == 1) begin
            rise_t <= cyc;
        end else if (ph == 2 && !eoc_done && !plan_never) begin
            if (cd == 0) begin adc_eoc_n <= 1'b0; eoc_done <= 1'b1; end
            else cd <= cd - 1;
        end
    end

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int unsigned min_gap(input logic shut);
        return shut ? (T_WAKE + T_ACQ) : T_ACQ;
    endfunction

    logic exp_shut = 1'b1;

    task automatic run_conv(input logic sb, input int unsigned dly, input logic never,
                            input logic [DW-1:0] d);
        int n;
        logic got_v, got_e;
        plan_dly = dly; plan_never = never; plan_data = d;
        start_standby = sb; start_valid = 1'b1;
        n = 0;
        while (!start_ready && n < 5000) begin @(negedge clk); n++; end
        @(negedge clk);
        start_valid = 1'b0;
        chk("R7 ready low after accept", !start_ready, start_ready, 0);
        got_v = 1'b0; got_e = 1'b0; n = 0;
        while (!got_v && !got_e && n < 5000) begin
            @(negedge clk); n++;
            got_v = sample_valid; got_e = timeout_err;
        end
        chk("R2 rc at first edge", rc1 == 1'b0, rc1, 0);
        chk("R3 rc at second edge", rc2 == sb, rc2, sb);
        chk("R4 track gap", gap >= T_ACQ, gap, T_ACQ);
        if (exp_shut) chk("R5 wake wait applied", gap >= min_gap(1'b1), gap, min_gap(1'b1));
        else          chk("R5 no wake wait", gap < T_WAKE, gap, T_ACQ);
        if (never) begin
            chk("R8 timeout flagged", got_e && !got_v, got_v, 0);
            chk("R8 reset pin high", adc_reset, adc_reset, 1);
            while (adc_reset) @(negedge clk);
            chk("R8 reset with cs high", rst_seen && !bad_rst, bad_rst, 0);
            exp_shut = 1'b1;
        end else begin
            chk("R6 sample returned", got_v, got_v, 1);
            chk("R6 sample data", sample_data == d, sample_data, d);
            chk("R6 rc high at read", rc_rd, rc_rd, 1);
            chk("R7 ready low at sample", !start_ready, start_ready, 0);
            @(negedge clk);
            chk("R6 valid one cycle", !sample_valid, sample_valid, 0);
            exp_shut = ~sb;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cs high", adc_cs_n, adc_cs_n, 1);
        chk("R1 reset low", !adc_reset, adc_reset, 0);
        chk("R1 valid low", !sample_valid, sample_valid, 0);
        chk("R1 ready high", start_ready, start_ready, 1);
        // R5: first conversion after reset must wait
        run_conv(1'b1, 10, 1'b0, 14'h3FFF);
        run_conv(1'b1, 4, 1'b0, 14'h0000);
        run_conv(1'b0, 20, 1'b0, 14'h1555);
        run_conv(1'b1, 7, 1'b0, 14'h2AAA);
        // R8: converter never completes
        run_conv(1'b1, 0, 1'b1, 14'h0123);
        run_conv(1'b1, 9, 1'b0, 14'h0456);
        for (int i = 0; i < 24; i++) begin
            run_conv(1'($urandom_range(0, 1)), $urandom_range(3, 60), 1'b0,
                     DW'($urandom_range(0, (1 << DW) - 1)));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule